// File: doc/BRIEF.md
# Variable-Length Instruction Parceling Unit

This unit sits between instruction fetch and decode/rename. Each fetch block it receives holds eight 16-bit parcels from one aligned 16-byte line. An instruction takes either one parcel or two. The unit walks the parcels from a saved offset, finds where each instruction starts and ends, and places up to four instructions per cycle into a fixed group of decode slots.

For every instruction it supplies the opcode, the accumulator index, the register/short-immediate field and, for two-parcel instructions, the 16-bit immediate. The first parcel alone tells the unit the length, so a single forward scan is enough. An instruction never runs past the end of a line, so the unit never has to join parcels from two blocks.

The unit holds the offset of the next unread parcel between cycles. It releases the block back to fetch only after every parcel in it has been consumed. When decode is not ready, the slot group stays frozen. A flush input empties the slots and sets the offset back to zero.

Top module: `parcel_split`

## Requirements
- R1: While reset is active, and in the first cycle after it, `slot_valid` is all zero and `blk_take` is low. The parcel offset starts at 0.
- R2: Parcel k of a block is `blk_data[16k+15:16k]`. Within a parcel, bits [15:9] are the opcode, [8:6] the accumulator index and [5:0] the register/short-immediate field. Opcode bit 15 set means a two-parcel instruction, and `slot_long` reports it.
- R3: For a two-parcel instruction, `slot_imm` of that slot carries the whole following parcel. Slots holding one-parcel instructions, and slots that are not valid, show zero in every field.
- R4: Instructions are placed in program order from slot 0 upward, with at most four per cycle. The valid slots always form a contiguous run that begins at slot 0.
- R5: After a cycle that does not finish the block, the next group starts at the parcel right after the last parcel consumed.
- R6: `blk_take` is high in the same cycle in which the group being loaded consumes the last parcel (parcel 7), and only then. The offset then returns to 0.
- R7: When any slot is valid and `out_ready` is low, all slot outputs keep their values, no parcel is consumed and `blk_take` stays low.
- R8: A flush clears all slots in the next cycle, sets the offset to 0 and holds `blk_take` low in the flush cycle.
- R9: A long marker in parcel 7 has no following parcel. That parcel is emitted as a one-parcel instruction, with `slot_long` low and the immediate zero.
- R10: When the unit can advance but `blk_valid` is low, the slots come out empty and the offset is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop slots and restart at parcel 0 |
| blk_valid | input | 1 | Fetch block present |
| blk_data | input | 128 | Eight parcels, parcel 0 in the low bits |
| blk_take | output | 1 | Block fully consumed this cycle |
| out_ready | input | 1 | Decode accepts the slot group |
| slot_valid | output | 4 | Per-slot valid |
| slot_long | output | 4 | Per-slot two-parcel flag |
| slot_opc | output | 28 | Opcodes, 7 bits per slot |
| slot_acc | output | 12 | Accumulator indices, 3 bits per slot |
| slot_reg | output | 24 | Register/short-immediate fields, 6 bits per slot |
| slot_imm | output | 64 | Long immediates, 16 bits per slot |

## Verification
The bench targets four cases.

- **Four long instructions filling a whole block.** The block must be released after a single group. A unit that counts instructions instead of parcels would keep the block one cycle too long and emit an empty group.
- **A long marker in the final parcel.** A unit that trusts the marker would read past the end of the block and consume nine parcels.
- **Stalls in the middle of a block.** These expose a unit that advances its offset while the slots are frozen, which silently drops instructions.
- **Flushes and idle gaps.** A flush arriving while slots are valid must not leak a stale group or a spurious `blk_take`. An idle gap must neither move the offset nor re-emit the last group.

// File: rtl/parcel_split.sv
module parcel_split #(
  parameter int SLOTS   = 4,
  parameter int PARCELS = 8,
  parameter int OPC_W   = 7,
  parameter int ACC_W   = 3,
  parameter int REG_W   = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush,
  input  logic                              blk_valid,
  input  logic [PARCELS*(OPC_W+ACC_W+REG_W)-1:0] blk_data,
  output logic                              blk_take,
  input  logic                              out_ready,
  output logic [SLOTS-1:0]                  slot_valid,
  output logic [SLOTS-1:0]                  slot_long,
  output logic [SLOTS*OPC_W-1:0]            slot_opc,
  output logic [SLOTS*ACC_W-1:0]            slot_acc,
  output logic [SLOTS*REG_W-1:0]            slot_reg,
  output logic [SLOTS*(OPC_W+ACC_W+REG_W)-1:0] slot_imm
);
  localparam int PW    = OPC_W + ACC_W + REG_W;
  localparam int OFF_W = $clog2(PARCELS);

  logic [OFF_W-1:0]       off;
  logic [SLOTS-1:0]       nx_valid, nx_long;
  logic [SLOTS*OPC_W-1:0] nx_opc;
  logic [SLOTS*ACC_W-1:0] nx_acc;
  logic [SLOTS*REG_W-1:0] nx_reg;
  logic [SLOTS*PW-1:0]    nx_imm;
  logic [PW-1:0]          par;
  logic                   lng;
  int                     pos;

  always_comb begin
    pos      = int'(off);
    par      = '0;
    lng      = 1'b0;
    nx_valid = '0;
    nx_long  = '0;
    nx_opc   = '0;
    nx_acc   = '0;
    nx_reg   = '0;
    nx_imm   = '0;
    for (int k = 0; k < SLOTS; k++) begin
      if (blk_valid && pos < PARCELS) begin
        par = blk_data[pos*PW +: PW];
        lng = par[PW-1] && (pos < PARCELS - 1);
        nx_valid[k] = 1'b1;
        nx_long[k]  = lng;
        nx_opc[k*OPC_W +: OPC_W] = par[PW-1 -: OPC_W];
        nx_acc[k*ACC_W +: ACC_W] = par[REG_W +: ACC_W];
        nx_reg[k*REG_W +: REG_W] = par[REG_W-1:0];
        if (lng) nx_imm[k*PW +: PW] = blk_data[(pos+1)*PW +: PW];
        pos = pos + (lng ? 2 : 1);
      end
    end
  end

  wire advance = !(|slot_valid) || out_ready;
  wire done    = pos >= PARCELS;

  assign blk_take = advance && blk_valid && !flush && done;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      off        <= '0;
      slot_valid <= '0;
      slot_long  <= '0;
      slot_opc   <= '0;
      slot_acc   <= '0;
      slot_reg   <= '0;
      slot_imm   <= '0;
    end else if (advance) begin
      slot_valid <= nx_valid;
      slot_long  <= nx_long;
      slot_opc   <= nx_opc;
      slot_acc   <= nx_acc;
      slot_reg   <= nx_reg;
      slot_imm   <= nx_imm;
      if (blk_valid) off <= done ? '0 : OFF_W'(pos);
    end
  end
endmodule

// File: rtl/parcel_split_chk.sv
module parcel_split_chk #(
  parameter int SLOTS = 4,
  parameter int OPC_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   flush,
  input logic                   blk_valid,
  input logic                   blk_take,
  input logic                   out_ready,
  input logic [SLOTS-1:0]       slot_valid,
  input logic [SLOTS*OPC_W-1:0] slot_opc
);
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_valid && !out_ready && !flush) |=> ($stable(slot_valid) && $stable(slot_opc)));

  assert_stall_notake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|slot_valid && !out_ready) |-> !blk_take);

  assert_take_needs_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_take |-> (blk_valid && !flush));

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_valid == '0));

  assert_idle_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_valid && !flush && (!(|slot_valid) || out_ready)) |=> (slot_valid == '0));

  assert_packed_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((SLOTS'(slot_valid + 1'b1) & slot_valid) == '0));
endmodule

bind parcel_split parcel_split_chk #(.SLOTS(SLOTS), .OPC_W(OPC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .blk_valid(blk_valid),
  .blk_take(blk_take), .out_ready(out_ready), .slot_valid(slot_valid),
  .slot_opc(slot_opc)
);

// File: tb/parcel_split_tb_top.sv
module parcel_split_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         blk_valid = 1'b0;
  logic [127:0] blk_data = '0;
  logic         blk_take;
  logic         out_ready = 1'b1;
  logic [3:0]   slot_valid, slot_long;
  logic [27:0]  slot_opc;
  logic [11:0]  slot_acc;
  logic [23:0]  slot_reg;
  logic [63:0]  slot_imm;

  always #5 clk = ~clk;

  parcel_split dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .blk_valid(blk_valid),
    .blk_data(blk_data), .blk_take(blk_take), .out_ready(out_ready),
    .slot_valid(slot_valid), .slot_long(slot_long), .slot_opc(slot_opc),
    .slot_acc(slot_acc), .slot_reg(slot_reg), .slot_imm(slot_imm)
  );

  int checks = 0;
  int errors = 0;
  logic [127:0] q[$];

  int          moff;
  logic [3:0]  mv, ml, nv, nl;
  logic [27:0] mo, no;
  logic [11:0] ma, na;
  logic [23:0] mr, nr;
  logic [63:0] mi, ni;
  logic        ntake;
  int          npos;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    moff = 0; mv = '0; ml = '0; mo = '0; ma = '0; mr = '0; mi = '0;
  endtask

  task automatic model_next();
    int p;
    logic [15:0] w;
    bit big;
    p = moff;
    nv = '0; nl = '0; no = '0; na = '0; nr = '0; ni = '0;
    for (int k = 0; k < 4; k++) begin
      if (blk_valid && p < 8) begin
        w = blk_data[p*16 +: 16];
        big = w[15] && p != 7;
        nv[k] = 1'b1;
        nl[k] = big;
        no[k*7 +: 7] = w[15:9];
        na[k*3 +: 3] = w[8:6];
        nr[k*6 +: 6] = w[5:0];
        if (big) begin
          ni[k*16 +: 16] = blk_data[(p+1)*16 +: 16];
          p += 2;
        end else p += 1;
      end
    end
    npos = p;
    ntake = (mv == 0 || out_ready) && blk_valid && !flush && p >= 8;
  endtask

  task automatic cyc(input bit fl, input bit rdy, input bit gap, input string tag);
    @(negedge clk);
    chk({"R4 ", tag}, "slot_valid", 64'(slot_valid), 64'(mv));
    chk({"R2 ", tag}, "slot_long",  64'(slot_long),  64'(ml));
    chk({"R2 ", tag}, "slot_opc",   64'(slot_opc),   64'(mo));
    chk({"R2 ", tag}, "slot_acc",   64'(slot_acc),   64'(ma));
    chk({"R2 ", tag}, "slot_reg",   64'(slot_reg),   64'(mr));
    chk({"R3 ", tag}, "slot_imm",   slot_imm,        mi);
    flush = fl;
    out_ready = rdy;
    blk_valid = !gap && q.size() > 0;
    blk_data = blk_valid ? q[0] : '0;
    model_next();
    #1;
    chk({"R6 ", tag}, "blk_take", 64'(blk_take), 64'(ntake));
    @(posedge clk);
    if (fl) model_clear();
    else if (mv == 0 || rdy) begin
      mv = nv; ml = nl; mo = no; ma = na; mr = nr; mi = ni;
      if (blk_valid) moff = ntake ? 0 : npos;
    end
    if (ntake) void'(q.pop_front());
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 20 && (q.size() > 0 || mv != 0); i++) cyc(1'b0, 1'b1, 1'b0, tag);
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "slot_valid in reset", 64'(slot_valid), 64'd0);
    chk("R1", "blk_take in reset", 64'(blk_take), 64'd0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b1, 1'b0, "R1");

    // all one-parcel: two groups, take on second
    q.push_back({16'h1047, 16'h1246, 16'h2445, 16'h3644, 16'h4843, 16'h5a42, 16'h6c41, 16'h7e40});
    drain("R5");
    // four two-parcel instructions fill the block in one group
    q.push_back({16'hbeef, 16'hf1c7, 16'h5678, 16'hc288, 16'h1234, 16'ha0c9, 16'hffff, 16'h8001});
    drain("R3");
    // mixed: S L imm S S L imm S
    q.push_back({16'h0111, 16'h4321, 16'h9a22, 16'h0333, 16'h0444, 16'hcafe, 16'h8555, 16'h0666});
    drain("R5");
    // long marker in the final parcel
    q.push_back({16'hfe3f, 16'h0007, 16'h0006, 16'h0005, 16'h0004, 16'h0003, 16'h0002, 16'h0001});
    drain("R9");
    // stall with a partly consumed block
    q.push_back({16'h0111, 16'h4321, 16'h9a22, 16'h0333, 16'h0444, 16'hcafe, 16'h8555, 16'h0666});
    cyc(1'b0, 1'b1, 1'b0, "R7");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, "R7");
    drain("R7");
    // flush mid-block, then restart from parcel 0
    q.push_back({16'h1047, 16'h1246, 16'h2445, 16'h3644, 16'h4843, 16'h5a42, 16'h6c41, 16'h7e40});
    cyc(1'b0, 1'b1, 1'b0, "R8");
    cyc(1'b1, 1'b0, 1'b0, "R8");
    cyc(1'b0, 1'b1, 1'b0, "R8");
    drain("R8");
    // idle gaps inside a block
    q.push_back({16'h0111, 16'h4321, 16'h9a22, 16'h0333, 16'h0444, 16'hcafe, 16'h8555, 16'h0666});
    cyc(1'b0, 1'b1, 1'b0, "R10");
    cyc(1'b0, 1'b1, 1'b1, "R10");
    cyc(1'b0, 1'b1, 1'b1, "R10");
    drain("R10");
    // random mix
    for (int i = 0; i < 600; i++) begin
      if (q.size() < 2) q.push_back({$urandom, $urandom, $urandom, $urandom});
      cyc(($urandom % 23) == 0, ($urandom % 4) != 0, ($urandom % 7) == 0, "R5");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule